// File: doc/BRIEF.md
# Oscillator Start-Up Delay Sequencer

This block controls how a small controller leaves its low-power stop state. While the chip runs, a one-cycle sleep request stops the oscillator and gates off the core clock. A later wake request turns the oscillator back on. The core clock stays gated while a settle timer waits for the oscillator to become stable.

The settle timer advances once per instruction cycle. An instruction cycle is produced by dividing the oscillator clock by ten. The timer starts at 256 whenever a wake is accepted, and the divider restarts from phase zero at the same moment. The wait is therefore always exactly 2560 oscillator clocks.

When the timer runs out, the core clock is released. In that first cycle the block gives a one-cycle indication of how execution continues. It either resumes at the instruction after the one that requested sleep, or it vectors to the wake interrupt routine first. The choice follows the interrupt-enable flag as it was sampled when the wake was accepted.

Top module: `osc_startup_seq`

## Requirements
- R1: During reset, and after reset is released, the block is running: `osc_en`=1, `core_clk_en`=1, and both `resume_next` and `vector_isr` are 0.
- R2: A `sleep_req` sampled high while running sets `osc_en`=0 and `core_clk_en`=0 from the next cycle. This also holds when `wake_req` is high in the same cycle.
- R3: While stopped and with no `wake_req`, `osc_en` and `core_clk_en` both stay 0.
- R4: A `wake_req` sampled high while stopped gives `osc_en`=1 and `core_clk_en`=0 from the next cycle.
- R5: The start-up window (`osc_en`=1, `core_clk_en`=0) lasts exactly DIV*DELAY = 2560 cycles, counted from the cycle after the wake is accepted.
- R6: `core_clk_en` rises only in the cycle right after the settle timer expires, and stays 0 for the whole window.
- R7: In the first cycle with `core_clk_en`=1, exactly one indication is pulsed. It is `resume_next` if `wake_irq_en` was 0 in the cycle the wake was accepted, and `vector_isr` if it was 1.
- R8: The indication lasts one cycle. In the next cycle the block is running with both indications 0.
- R9: `wake_req` has no effect unless the block is stopped. It does not alter the running state, and it does not restart or lengthen the window.
- R10: `sleep_req` is ignored unless the block is running. This covers the stopped state, the window, and the indication cycle, after which the block is running.
- R11: The window length does not depend on how long the block ran before sleeping, because the divider restarts when a wake is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | Request to enter the stopped state (one cycle) |
| wake_req | input | 1 | Wake request from the wake logic |
| wake_irq_en | input | 1 | Wake interrupt enabled; sampled when a wake is accepted |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Clock enable to the rest of the chip |
| resume_next | output | 1 | One-cycle pulse: continue at the next instruction |
| vector_isr | output | 1 | One-cycle pulse: enter the wake interrupt routine |

## Verification
Each result has a fixed latency, and the bench samples it there. A sleep or wake request takes effect one cycle after the edge that samples it. The core clock returns 2560 cycles after the wake edge, together with the resume or vector pulse. The pulse is cleared one cycle later.

The bench drives inputs and reads outputs on the falling edge. It counts the window cycle by cycle until `core_clk_en` rises, and compares the count with the value computed from DIV and DELAY. In the same sample it checks the pulse type, using the interrupt flag it applied on the wake edge. Random wake, sleep and flag noise is applied in every phase to check that requests outside their own state are ignored.

// File: rtl/oscwake_pkg.sv
package oscwake_pkg;
  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_HALT   = 2'd1,
    PH_START  = 2'd2,
    PH_RESUME = 2'd3
  } phase_e;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cyc_divider.sv
module cyc_divider #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = run && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Instruction-cycle ticks are never back to back (R5)
  p_tick_spaced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // Clearing restarts the phase at zero (R11)
  p_clr_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int COUNT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic expire
);
  localparam int W = $clog2(COUNT + 1);
  localparam logic [W-1:0] INIT = W'(COUNT);

  logic [W-1:0] cnt_q, cnt_d;

  assign expire = step && !load && (cnt_q == W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)                       cnt_d = INIT;
    else if (step && cnt_q != '0)   cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Timer is never stepped once it has run out (R5)
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> (cnt_q != '0));
  // Load starts from the full delay (R5)
  p_load_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == INIT));
endmodule

// File: rtl/osc_startup_seq.sv
module osc_startup_seq
  import oscwake_pkg::*;
#(
  parameter int DIV   = 10,
  parameter int DELAY = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic wake_irq_en,
  output logic osc_en,
  output logic core_clk_en,
  output logic resume_next,
  output logic vector_isr
);
  logic   rst_sync_n;
  phase_e phase_q, phase_d;
  logic   irq_sel_q, irq_sel_d;
  logic   start_go;
  logic   ic_tick;
  logic   tmr_step;
  logic   tmr_expire;

  rst_release_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  cyc_divider #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (start_go),
    .run  (osc_en),
    .tick (ic_tick)
  );

  assign tmr_step = ic_tick && (phase_q == PH_START);

  settle_timer #(.COUNT(DELAY)) u_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (start_go),
    .step  (tmr_step),
    .expire(tmr_expire)
  );

  always_comb begin
    phase_d   = phase_q;
    irq_sel_d = irq_sel_q;
    start_go  = 1'b0;
    unique case (phase_q)
      PH_RUN:    if (sleep_req) phase_d = PH_HALT;
      PH_HALT: begin
        if (wake_req) begin
          phase_d   = PH_START;
          start_go  = 1'b1;
          irq_sel_d = wake_irq_en;
        end
      end
      PH_START:  if (tmr_expire) phase_d = PH_RESUME;
      PH_RESUME: phase_d = PH_RUN;
      default:   phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q   <= PH_RUN;
      irq_sel_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      irq_sel_q <= irq_sel_d;
    end
  end

  assign osc_en      = (phase_q != PH_HALT);
  assign core_clk_en = (phase_q == PH_RUN) || (phase_q == PH_RESUME);
  assign resume_next = (phase_q == PH_RESUME) && !irq_sel_q;
  assign vector_isr  = (phase_q == PH_RESUME) &&  irq_sel_q;

  p_sleep_enter_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_RUN && sleep_req) |=> (!osc_en && !core_clk_en));
  p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!osc_en && !wake_req) |=> (!osc_en && !core_clk_en));
  p_wake_start_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!osc_en && wake_req) |=> (osc_en && !core_clk_en));
  p_gate_after_expire_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(core_clk_en) |-> $past(tmr_expire));
  p_pulse_at_gate_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(core_clk_en) |-> (resume_next || vector_isr));
  p_pulse_onehot_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({resume_next, vector_isr}));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (resume_next || vector_isr) |=> (!resume_next && !vector_isr && core_clk_en && osc_en));
  p_sleep_ignored_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (resume_next || vector_isr) |=> osc_en);
endmodule

// File: tb/osc_startup_seq_tb_top.sv
module osc_startup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 10;
  localparam int DELAY = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic sleep_req, wake_req, wake_irq_en;
  logic osc_en, core_clk_en, resume_next, vector_isr;

  int checks = 0;
  int errors = 0;

  osc_startup_seq #(.DIV(DIV), .DELAY(DELAY)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .wake_req   (wake_req),
    .wake_irq_en(wake_irq_en),
    .osc_en     (osc_en),
    .core_clk_en(core_clk_en),
    .resume_next(resume_next),
    .vector_isr (vector_isr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_window();
    return DIV * DELAY;
  endfunction

  function automatic logic [1:0] exp_pulse(input logic irq);
    return irq ? 2'b01 : 2'b10;  // {resume_next, vector_isr}
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_state(input string req, input logic eo, input logic ec);
    chk(osc_en === eo && core_clk_en === ec, req,
        int'({osc_en, core_clk_en}), int'({eo, ec}));
  endtask

  task automatic one_round(input int run_cyc, input int halt_cyc, input logic irq,
                           input bit noise, input bit sleep_in_resume);
    int n;
    for (int i = 0; i < run_cyc; i++) begin
      wake_req = noise ? 1'($urandom % 2) : 1'b0;
      sleep_req = 1'b0;
      wake_irq_en = 1'($urandom % 2);
      @(negedge clk);
      chk_state("R9 wake in run ignored", 1'b1, 1'b1);
    end
    sleep_req = 1'b1;
    wake_req = noise ? 1'($urandom % 2) : 1'b0;
    @(negedge clk);
    chk_state("R2 sleep entry", 1'b0, 1'b0);
    for (int i = 0; i < halt_cyc; i++) begin
      sleep_req = noise ? 1'($urandom % 2) : 1'b0;
      wake_req = 1'b0;
      @(negedge clk);
      chk_state("R3 R10 halted", 1'b0, 1'b0);
    end
    wake_req = 1'b1;
    sleep_req = noise ? 1'($urandom % 2) : 1'b0;
    wake_irq_en = irq;
    @(negedge clk);
    chk_state("R4 wake starts oscillator", 1'b1, 1'b0);
    n = 1;
    while (core_clk_en === 1'b0 && n < 6000) begin
      wake_req = noise ? 1'($urandom % 2) : 1'b0;
      sleep_req = noise ? 1'($urandom % 2) : 1'b0;
      wake_irq_en = 1'($urandom % 2);
      @(negedge clk);
      if (core_clk_en === 1'b0) begin
        n++;
        if (osc_en !== 1'b1) chk(1'b0, "R6 oscillator during window", int'(osc_en), 1);
      end
    end
    chk(n == exp_window(), "R5 R9 R11 window length", n, exp_window());
    chk(core_clk_en === 1'b1 && osc_en === 1'b1, "R6 core released", int'(core_clk_en), 1);
    chk({resume_next, vector_isr} === exp_pulse(irq), "R7 indication type",
        int'({resume_next, vector_isr}), int'(exp_pulse(irq)));
    sleep_req = sleep_in_resume;
    wake_req = 1'b0;
    @(negedge clk);
    chk({resume_next, vector_isr} === 2'b00, "R8 indication one cycle",
        int'({resume_next, vector_isr}), 0);
    chk_state("R8 R10 running after indication", 1'b1, 1'b1);
    sleep_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7305));
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; wake_irq_en = 1'b0;
    repeat (3) @(negedge clk);
    chk_state("R1 reset state", 1'b1, 1'b1);
    chk({resume_next, vector_isr} === 2'b00, "R1 no pulse in reset",
        int'({resume_next, vector_isr}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_state("R1 after reset", 1'b1, 1'b1);

    one_round(3, 2, 1'b0, 1'b0, 1'b0);
    one_round(0, 0, 1'b1, 1'b0, 1'b1);
    one_round(7, 5, 1'b1, 1'b1, 1'b1);
    one_round(1, 1, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++)
      one_round(int'($urandom % 23), int'($urandom % 9), 1'($urandom % 2),
                1'b1, 1'($urandom % 2));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule